// File: doc/BRIEF.md
# Escalating Per-Core Watchdog Timer

This block guards a single processor core. Software loads a reload length, an escalation mode and a clock divisor through a control write. The block then counts down on a prescaled clock. If software fails to service it, the block escalates one level each time the countdown runs out. The first expiry raises an interrupt request. The second raises a non-maskable interrupt request. The third issues a single-cycle request for a chip-wide soft reset. A poke write restarts the countdown and drops the block back to the quiet level.

The countdown register is wider than the length field. The length fills its upper bits and the lower `LOW_W` bits load as zero, so one period is `LEN × 2^LOW_W` prescaled ticks. The prescaler divides the input clock by `2^DIV_LOG2_MIN`, twice that, or four times that, as the divisor code selects. With the default parameters this gives 256, 512 or 1024. The live count is visible at all times on an output port, so software can compare it against a threshold. The escalation level is visible in the same way.

Top module: `wdog_stage_timer`

## Requirements
- R1: After reset the count reads 0, the level reads 0, and `irq_o`, `nmi_o` and `rst_req_o` are low.
- R2: A control write (`cfg_we`) loads the count with `{cfg_len, LOW_W zero bits}`, clears the level to 0 and restarts the prescaler, all at that clock edge.
- R3: Divisor code 0 divides by `2^DIV_LOG2_MIN`, code 1 by twice that, and codes 2 and 3 by four times that. The first decrement comes exactly one divided interval after the load edge.
- R4: With mode ≥ 1 and no poke, level 1 (interrupt) begins exactly `LEN·2^LOW_W·divisor` clocks after the load edge. `irq_o` is high whenever the level is 1 or more, so it rises at that edge.
- R5: With mode ≥ 2, level 2 (NMI) begins one further period later. `nmi_o` is high whenever the level is 2 or more, and `irq_o` stays high alongside it.
- R6: With mode 3, level 3 begins one further period after level 2. `rst_req_o` is high for exactly the one cycle after that edge and never pulses again until the level has been cleared.
- R7: The level never exceeds the mode value. Mode 1 stops at the interrupt and mode 2 stops at the NMI, while the count keeps running and reloading.
- R8: A poke (`poke_we`) at any level reloads the count from the stored length, restarts the prescaler and returns the level to 0 at that edge. The next escalation follows a full period later.
- R9: While the stored mode is 0, the count and level never change except through a control write or a poke.
- R10: Each expiry reloads the count to `LEN·2^LOW_W`. Between expiries the count steps down by one per prescaled tick, so one period is exactly `LEN·2^LOW_W` ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_len | input | LEN_W | Reload length written by the control write |
| cfg_mode | input | 2 | Escalation limit: 0 off, 1 interrupt, 2 NMI, 3 soft reset |
| cfg_div | input | SEL_W | Divisor code |
| poke_we | input | 1 | Poke strobe (service the watchdog) |
| count_o | output | LEN_W+LOW_W | Live countdown value |
| stage_o | output | 2 | Current escalation level 0..3 |
| irq_o | output | 1 | Interrupt request; its rising edge marks level 1 |
| nmi_o | output | 1 | Non-maskable interrupt request |
| rst_req_o | output | 1 | One-cycle soft-reset request |

## Verification
A wrong prescaler or countdown state shows up on `count_o` within one divided interval of a control write. It also shifts the edge where `irq_o` rises, which the bench samples at exactly `LEN·2^LOW_W·divisor` clocks. A wrong level register shows up on `stage_o`, `irq_o` and `nmi_o` at the very next expiry, or on the cycle after a poke. A missing or repeated `rst_req_o` pulse is caught in the cycle after level 3 begins, and again in the hundred cycles that follow.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int MODE_W = 2;

   typedef enum logic [1:0] {
      LVL_QUIET = 2'd0,
      LVL_IRQ   = 2'd1,
      LVL_NMI   = 2'd2,
      LVL_RESET = 2'd3
   } wdog_level_e;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
   parameter int DIV_LOG2_MIN = 8,
   parameter int NUM_DIV      = 3,
   parameter int SEL_W        = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int PRE_W = DIV_LOG2_MIN + NUM_DIV - 1;
   localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(NUM_DIV - 1);

   initial begin
      assert (DIV_LOG2_MIN >= 1) else $error("DIV_LOG2_MIN must be at least 1");
      assert (NUM_DIV >= 1 && NUM_DIV <= (1 << SEL_W)) else $error("NUM_DIV must fit the divisor code");
   end

   logic [PRE_W-1:0]   pre_q;
   logic [NUM_DIV-1:0] wrap_opt;
   logic [SEL_W-1:0]   sel_c;

   // One terminal-count detector for each selectable divisor.
   for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
      assign wrap_opt[g] = &pre_q[DIV_LOG2_MIN+g-1:0];
   end

   always_comb begin
      sel_c = (sel > SEL_MAX) ? SEL_MAX : sel;
      tick  = wrap_opt[sel_c] & ~restart;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre_q <= '0;
      else if (restart) pre_q <= '0;
      else              pre_q <= pre_q + 1'b1;
   end
endmodule

// File: rtl/wdog_downcount.sv
module wdog_downcount #(
   parameter int LEN_W = 16,
   parameter int LOW_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load,
   input  logic [LEN_W-1:0]       len,
   input  logic                   run,
   input  logic                   tick,
   output logic [LEN_W+LOW_W-1:0] count,
   output logic                   expire
);
   localparam int CNT_W = LEN_W + LOW_W;

   initial begin
      assert (LEN_W >= 1 && LOW_W >= 0) else $error("bad counter widths");
   end

   logic [CNT_W-1:0] reload;

   always_comb begin
      reload = {len, {LOW_W{1'b0}}};
      expire = run & tick & ~load & (count == CNT_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            count <= '0;
      else if (load)                         count <= reload;
      else if (expire)                       count <= reload;
      else if (run && tick && count != '0)   count <= count - 1'b1;
   end
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
   import wdog_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              expire,
   input  logic [MODE_W-1:0] mode,
   output wdog_level_e       level,
   output logic              rst_pulse
);
   logic may_step;

   always_comb may_step = expire & ~clear & (MODE_W'(level) < mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level     <= LVL_QUIET;
         rst_pulse <= 1'b0;
      end else begin
         rst_pulse <= may_step & (level == LVL_NMI);
         if (clear)         level <= LVL_QUIET;
         else if (may_step) level <= wdog_level_e'(level + 2'd1);
      end
   end
endmodule

// File: rtl/wdog_stage_timer.sv
module wdog_stage_timer
   import wdog_pkg::*;
#(
   parameter int LEN_W        = 16,
   parameter int LOW_W        = 8,
   parameter int DIV_LOG2_MIN = 8,
   parameter int NUM_DIV      = 3,
   parameter int SEL_W        = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [LEN_W-1:0]       cfg_len,
   input  logic [1:0]             cfg_mode,
   input  logic [SEL_W-1:0]       cfg_div,
   input  logic                   poke_we,
   output logic [LEN_W+LOW_W-1:0] count_o,
   output logic [1:0]             stage_o,
   output logic                   irq_o,
   output logic                   nmi_o,
   output logic                   rst_req_o
);
   logic [LEN_W-1:0]  len_q;
   logic [MODE_W-1:0] mode_q;
   logic [SEL_W-1:0]  div_q;
   logic              restart, tick, expire, running;
   wdog_level_e       level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q  <= '0;
         mode_q <= '0;
         div_q  <= '0;
      end else if (cfg_we) begin
         len_q  <= cfg_len;
         mode_q <= cfg_mode;
         div_q  <= cfg_div;
      end
   end

   always_comb begin
      restart = cfg_we | poke_we;
      running = (mode_q != '0);
   end

   // A control write must use the incoming settings in the same edge.
   wdog_prescale #(
      .DIV_LOG2_MIN(DIV_LOG2_MIN), .NUM_DIV(NUM_DIV), .SEL_W(SEL_W)
   ) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(restart), .sel(div_q), .tick(tick)
   );

   wdog_downcount #(.LEN_W(LEN_W), .LOW_W(LOW_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(restart),
      .len(cfg_we ? cfg_len : len_q),
      .run(running), .tick(tick), .count(count_o), .expire(expire)
   );

   wdog_escalate u_lvl (
      .clk(clk), .rst_n(rst_n), .clear(restart), .expire(expire),
      .mode(mode_q), .level(level), .rst_pulse(rst_req_o)
   );

   always_comb begin
      stage_o = level;
      irq_o   = (level != LVL_QUIET);
      nmi_o   = (level == LVL_NMI) || (level == LVL_RESET);
   end
endmodule

// File: rtl/wdog_stage_timer_chk.sv
module wdog_stage_timer_chk #(
   parameter int LEN_W = 16,
   parameter int LOW_W = 8,
   parameter int SEL_W = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cfg_we,
   input logic [LEN_W-1:0]       cfg_len,
   input logic [1:0]             cfg_mode,
   input logic [SEL_W-1:0]       cfg_div,
   input logic                   poke_we,
   input logic [LEN_W+LOW_W-1:0] count_o,
   input logic [1:0]             stage_o,
   input logic                   irq_o,
   input logic                   nmi_o,
   input logic                   rst_req_o
);
   logic [1:0] seen_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      seen_mode <= 2'd0;
      else if (cfg_we) seen_mode <= cfg_mode;
   end

   // R2
   load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (count_o == {$past(cfg_len), {LOW_W{1'b0}}}) && (stage_o == 2'd0));

   // R5
   nmi_implies_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_o |-> irq_o);

   // R6
   reset_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |=> !rst_req_o);

   // R6
   reset_after_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> (stage_o == 2'd3) && nmi_o);

   // R7
   level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stage_o <= seen_mode);

   // R8
   poke_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      poke_we |=> !irq_o && !nmi_o && (stage_o == 2'd0));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_mode == 2'd0 && !cfg_we && !poke_we) |=> $stable(count_o) && $stable(stage_o));
endmodule

bind wdog_stage_timer wdog_stage_timer_chk #(
   .LEN_W(LEN_W), .LOW_W(LOW_W), .SEL_W(SEL_W)
) u_chk (.*);

// File: tb/test_wdog_stage_timer.sv
module test_wdog_stage_timer;
   localparam int LEN_W = 16;
   localparam int LOW_W = 2;
   localparam int DMIN  = 1;
   localparam int CNT_W = LEN_W + LOW_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0, poke_we = 1'b0;
   logic [LEN_W-1:0] cfg_len = '0;
   logic [1:0] cfg_mode = '0, cfg_div = '0;
   logic [CNT_W-1:0] count_o;
   logic [1:0] stage_o;
   logic irq_o, nmi_o, rst_req_o;

   int n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   wdog_stage_timer #(.LEN_W(LEN_W), .LOW_W(LOW_W), .DIV_LOG2_MIN(DMIN)) i_wdog_stage_timer (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len(cfg_len), .cfg_mode(cfg_mode),
      .cfg_div(cfg_div), .poke_we(poke_we), .count_o(count_o), .stage_o(stage_o),
      .irq_o(irq_o), .nmi_o(nmi_o), .rst_req_o(rst_req_o)
   );

   typedef struct packed {
      logic [15:0] len;
      logic [1:0]  mode;
      logic [1:0]  sel;
      logic [15:0] wait_c;
      logic [1:0]  st;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{16'd2, 2'd3, 2'd0, 16'd15,  2'd0},
      '{16'd2, 2'd3, 2'd0, 16'd16,  2'd1},
      '{16'd2, 2'd3, 2'd0, 16'd32,  2'd2},
      '{16'd2, 2'd3, 2'd0, 16'd48,  2'd3},
      '{16'd2, 2'd3, 2'd0, 16'd100, 2'd3},
      '{16'd1, 2'd1, 2'd1, 16'd40,  2'd1},
      '{16'd3, 2'd2, 2'd2, 16'd300, 2'd2},
      '{16'd1, 2'd2, 2'd3, 16'd7,   2'd0},
      '{16'd5, 2'd3, 2'd0, 16'd39,  2'd0},
      '{16'd5, 2'd3, 2'd0, 16'd40,  2'd1}
   };

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cfg(input int len, input int mode, input int sel);
      @(negedge clk);
      cfg_we = 1'b1; cfg_len = LEN_W'(len); cfg_mode = 2'(mode); cfg_div = 2'(sel);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic poke();
      @(negedge clk); poke_we = 1'b1;
      @(negedge clk); poke_we = 1'b0;
   endtask

   task automatic adv(input int w);
      repeat (w) @(posedge clk);
      @(negedge clk);
   endtask

   // Expected count from R3/R10: ticks every d clocks, period of len*2^LOW_W ticks.
   function automatic int model_count(input int len, input int sel, input int w);
      int d, n, t;
      d = 1 << (DMIN + ((sel > 2) ? 2 : sel));
      n = len << LOW_W;
      t = w / d;
      return n - (t % n);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int pulses;
      repeat (3) @(negedge clk);
      // R1
      chk("R1 count", int'(count_o), 0);
      chk("R1 level", int'(stage_o), 0);
      chk("R1 outputs", int'({irq_o, nmi_o, rst_req_o}), 0);
      rst_n = 1'b1;
      adv(2);

      // R3 R4 R5 R7 R10: table walk
      for (int i = 0; i < NV; i++) begin
         cfg(VECS[i].len, VECS[i].mode, VECS[i].sel);
         adv(VECS[i].wait_c);
         chk($sformatf("R4/R7 level v%0d", i), int'(stage_o), int'(VECS[i].st));
         chk($sformatf("R5 irq/nmi v%0d", i), int'({irq_o, nmi_o}),
             int'({VECS[i].st >= 2'd1, VECS[i].st >= 2'd2}));
         chk($sformatf("R3/R10 count v%0d", i), int'(count_o),
             model_count(VECS[i].len, VECS[i].sel, VECS[i].wait_c));
      end

      // R2: load value right after the control write
      cfg(7, 3, 1);
      chk("R2 load", int'(count_o), 28);
      chk("R2 level clear", int'(stage_o), 0);

      // R6: single reset pulse at 3 periods
      cfg(2, 3, 0);
      adv(47);
      chk("R6 no pulse early", int'(rst_req_o), 0);
      chk("R6 level before", int'(stage_o), 2);
      adv(1);
      chk("R6 pulse", int'(rst_req_o), 1);
      chk("R6 level", int'(stage_o), 3);
      pulses = 0;
      for (int k = 0; k < 100; k++) begin
         @(negedge clk);
         pulses += int'(rst_req_o);
      end
      chk("R6 no repeat", pulses, 0);

      // R8: poke from each level
      cfg(2, 3, 0);
      adv(16);
      chk("R8 reach irq", int'(irq_o), 1);
      poke();
      chk("R8 clear from irq", int'({irq_o, nmi_o, stage_o}), 0);
      chk("R8 reload", int'(count_o), 8);
      adv(15);
      chk("R8 full period quiet", int'(irq_o), 0);
      adv(1);
      chk("R8 irq after period", int'(irq_o), 1);
      adv(16);
      chk("R8 reach nmi", int'(nmi_o), 1);
      poke();
      chk("R8 clear from nmi", int'({irq_o, nmi_o, stage_o}), 0);
      adv(48);
      chk("R8 reach reset level", int'(stage_o), 3);
      poke();
      chk("R8 clear from reset level", int'({irq_o, nmi_o, stage_o}), 0);

      // R9: mode 0 holds everything
      cfg(2, 0, 0);
      chk("R9 load", int'(count_o), 8);
      adv(50);
      chk("R9 count held", int'(count_o), 8);
      chk("R9 level held", int'({irq_o, nmi_o, stage_o}), 0);
      poke();
      chk("R9 poke no change", int'(count_o), 8);

      finish_run();
   end
endmodule